// File: doc/BRIEF.md
# Redundant-Receiver Packet Validator and Deduplicator

The block takes two byte streams from a pair of redundant receivers. Each stream carries packets of three parts, in this order: a fixed 15-byte header, a payload whose length the header gives, and a 16-bit checksum. Each receive lane parses and validates its own traffic and stores every good packet in a two-slot buffer. A packet is good when its identifying first byte is correct, its hop counter is not exhausted and its checksum matches.

A merge stage takes stored packets from the two lanes in round-robin order. It looks up the pair (sending node, sequence number) in a small history of recently forwarded packets. A match means the packet is the copy already delivered from the other receiver, so it is discarded. Otherwise the header and payload go out as one contiguous byte stream with the hop counter decremented. The parsed header fields are held stable on sideband outputs for the whole packet. The checksum bytes are not forwarded.

Top module: `phv_top`

## Requirements
- R1: After reset, and until a valid packet has been received, `out_valid` is low.
- R2: The header byte offsets are: 0 marker, 1 version, 2 service class, 3 hop counter, 4 transceiver id, 5 function code, 6 payload length, 7-8 source address, 9-10 destination address, 11 sending node, 12 target node, 13-14 sequence number. The 16-bit fields are sent MSB first. Each field appears on its sideband output for the whole forwarded packet.
- R3: A packet whose byte 0 differs from the MAGIC parameter (default 8'hA5) is discarded.
- R4: The checksum is the 16-bit end-around-carry (one's-complement) sum of all header and payload bytes, each zero-extended. It follows the payload, MSB first. On a mismatch the packet is discarded and leaves no entry in the history.
- R5: A packet with hop counter 0 is discarded. Otherwise the counter is decremented by one, both in forwarded byte 3 and on `out_ttl`.
- R6: A forwarded packet is bytes 0 to 14+L of the received packet, where L is the payload length. It goes out on consecutive cycles, with `out_sop` on the first byte and `out_eop` on the last.
- R7: A packet whose (sending node, sequence number) pair matches a previously forwarded packet in the history is discarded. This holds whichever lane it arrives on. Packets with the same sequence number but different nodes are distinct.
- R8: The history holds the last DEDUP_DEPTH (default 8) forwarded pairs, oldest replaced first. An evicted pair is forwarded again if it reappears.
- R9: `out_diag` is high for a packet whose function code has bit 7 set, which marks a diagnostic packet. It is low for an ordinary data packet.
- R10: Bytes that arrive with `rx_sop` low while a lane is idle are ignored. An `rx_sop` in the middle of a packet abandons that packet and starts a new one.
- R11: Two distinct packets that complete on both lanes in the same cycle are both forwarded, one after the other.
- R12: With the merge stage idle, `out_sop` for a packet rises at the third rising clock edge after the edge that samples its last checksum byte, counting the sampling edge as the first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 2 | Byte valid, one bit per receiver |
| rx_sop | input | 2 | First byte of a packet, per receiver |
| rx_data | input | 16 | Receiver bytes, lane n in bits 8n+7:8n |
| out_valid | output | 1 | Output byte valid |
| out_sop | output | 1 | First byte of a forwarded packet |
| out_eop | output | 1 | Last byte of a forwarded packet |
| out_data | output | 8 | Forwarded byte |
| out_ver | output | 8 | Version field |
| out_qos | output | 8 | Service class field |
| out_ttl | output | 8 | Decremented hop counter |
| out_xcvr | output | 8 | Sending transceiver id |
| out_func | output | 8 | Function code |
| out_diag | output | 1 | Diagnostic packet flag |
| out_plen | output | 8 | Payload length |
| out_src | output | 16 | Source address |
| out_dst | output | 16 | Destination address |
| out_snode | output | 8 | Sending node |
| out_tnode | output | 8 | Target node |
| out_seq | output | 16 | Sequence number |

## Verification
The accept or drop decision for a packet is made at the edge that samples its last checksum byte. The merge stage picks the packet one edge later, and the first output byte is registered on the edge after that. A dropped packet therefore never shows on the outputs, and the output byte stream of a forwarded packet lasts 15+L cycles. The bench first lets both lanes and the merge stage drain for a window longer than that whole path, then compares the number of packets collected, their bytes and their sideband fields. The one exact-cycle check measures the R12 distance between the cycle in which the last checksum byte was driven and the cycle in which `out_sop` is seen, with the merge stage idle.

// File: rtl/phv_pkg.sv
package phv_pkg;
  localparam int HDR_BYTES = 15;
  localparam int OFF_TTL   = 3;

  typedef struct packed {
    logic [7:0]  magic;
    logic [7:0]  ver;
    logic [7:0]  qos;
    logic [7:0]  ttl;
    logic [7:0]  xcvr;
    logic [7:0]  func;
    logic [7:0]  plen;
    logic [15:0] src;
    logic [15:0] dst;
    logic [7:0]  snode;
    logic [7:0]  tnode;
    logic [15:0] seq;
  } hdr_t;

  function automatic logic [15:0] oc_add(input logic [15:0] a, input logic [7:0] b);
    logic [16:0] s;
    s = {1'b0, a} + {9'd0, b};
    return s[15:0] + {15'd0, s[16]};
  endfunction
endpackage

// File: rtl/phv_rx_lane.sv
module phv_rx_lane
  import phv_pkg::*;
#(
  parameter logic [7:0] MAGIC       = 8'hA5,
  parameter int         MAX_PAYLOAD = 255,
  parameter int         AW          = $clog2(HDR_BYTES + MAX_PAYLOAD + 2)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          in_sop,
  input  logic [7:0]    in_data,
  input  logic [AW-1:0] rd_addr,
  input  logic          release_i,
  output logic          pend_o,
  output hdr_t          pend_hdr_o,
  output logic [7:0]    rd_q_o
);
  localparam int DEPTH = 2 << AW;

  logic [7:0]    mem [DEPTH];
  logic          busy, drop;
  logic [AW-1:0] idx;
  hdr_t          hdr;
  logic [15:0]   acc;
  logic [7:0]    ck_hi;
  logic [1:0]    full;
  logic          wr_slot, rd_slot;
  hdr_t          slot_hdr [2];

  logic          active, is_body, drop_eff, wen, verdict, good;
  logic [AW-1:0] pos, body_end;
  logic [7:0]    wbyte;
  hdr_t          hdr_out;

  always_comb begin
    active   = in_valid && (in_sop || busy);
    pos      = in_sop ? '0 : idx;
    body_end = AW'(HDR_BYTES) + AW'(hdr.plen);
    is_body  = (pos < AW'(HDR_BYTES)) || (pos < body_end);
    drop_eff = in_sop ? full[wr_slot] : drop;
    wen      = active && is_body && !drop_eff;
    wbyte    = (pos == AW'(OFF_TTL)) ? in_data - 8'd1 : in_data;
    verdict  = active && !in_sop && (pos == body_end + AW'(1));
    good     = !drop && (hdr.magic == MAGIC) && (hdr.ttl != 8'd0) &&
               ({ck_hi, in_data} == acc);
    hdr_out      = hdr;
    hdr_out.ttl  = hdr.ttl - 8'd1;
  end

  // packet store: one write port from the receiver, one read port for the merger
  always_ff @(posedge clk) begin
    if (wen) mem[{wr_slot, pos}] <= wbyte;
    rd_q_o <= mem[{rd_slot, rd_addr}];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      drop    <= 1'b0;
      idx     <= '0;
      hdr     <= '0;
      acc     <= '0;
      ck_hi   <= '0;
      full    <= '0;
      wr_slot <= 1'b0;
      rd_slot <= 1'b0;
      slot_hdr[0] <= '0;
      slot_hdr[1] <= '0;
    end else begin
      if (release_i) begin
        full[rd_slot] <= 1'b0;
        rd_slot       <= ~rd_slot;
      end
      if (active) begin
        idx  <= pos + AW'(1);
        busy <= 1'b1;
        if (in_sop) begin
          drop <= full[wr_slot];
          acc  <= {8'd0, in_data};
        end else if (is_body) begin
          acc <= oc_add(acc, in_data);
        end
        case (pos)
          AW'(0):  hdr.magic      <= in_data;
          AW'(1):  hdr.ver        <= in_data;
          AW'(2):  hdr.qos        <= in_data;
          AW'(3):  hdr.ttl        <= in_data;
          AW'(4):  hdr.xcvr       <= in_data;
          AW'(5):  hdr.func       <= in_data;
          AW'(6):  hdr.plen       <= in_data;
          AW'(7):  hdr.src[15:8]  <= in_data;
          AW'(8):  hdr.src[7:0]   <= in_data;
          AW'(9):  hdr.dst[15:8]  <= in_data;
          AW'(10): hdr.dst[7:0]   <= in_data;
          AW'(11): hdr.snode      <= in_data;
          AW'(12): hdr.tnode      <= in_data;
          AW'(13): hdr.seq[15:8]  <= in_data;
          AW'(14): hdr.seq[7:0]   <= in_data;
          default: ;
        endcase
        if (!in_sop && !is_body && pos == body_end) ck_hi <= in_data;
        if (verdict) begin
          busy <= 1'b0;
          if (good) begin
            full[wr_slot]     <= 1'b1;
            slot_hdr[wr_slot] <= hdr_out;
            wr_slot           <= ~wr_slot;
          end
        end
      end
    end
  end

  assign pend_o     = full[rd_slot];
  assign pend_hdr_o = slot_hdr[rd_slot];
endmodule

// File: rtl/phv_dedup_table.sv
module phv_dedup_table #(
  parameter int DEPTH = 8,
  parameter int KW    = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [KW-1:0] lk_key,
  output logic          hit,
  input  logic          ins,
  input  logic [KW-1:0] ins_key
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [KW-1:0]    ent_k [DEPTH];
  logic [DEPTH-1:0] ent_v;
  logic [DEPTH-1:0] match;
  logic [PW-1:0]    wp;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign match[g] = ent_v[g] && (ent_k[g] == lk_key);
  end
  assign hit = |match;

  always_ff @(posedge clk) begin
    if (rst) begin
      ent_v <= '0;
      wp    <= '0;
    end else if (ins) begin
      ent_v[wp] <= 1'b1;
      wp        <= (wp == PW'(DEPTH - 1)) ? '0 : wp + PW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (ins) ent_k[wp] <= ins_key;
  end
endmodule

// File: rtl/phv_merge.sv
module phv_merge
  import phv_pkg::*;
#(
  parameter int AW          = 9,
  parameter int DEDUP_DEPTH = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [1:0]            pend,
  input  hdr_t [1:0]            lane_hdr,
  input  logic [1:0][7:0]       lane_q,
  output logic [AW-1:0]         rd_addr,
  output logic [1:0]            release_o,
  output logic                  out_valid,
  output logic                  out_sop,
  output logic                  out_eop,
  output logic [7:0]            out_data,
  output hdr_t                  out_hdr,
  output logic                  out_diag
);
  typedef enum logic {M_IDLE, M_SEND} mstate_t;

  mstate_t       st;
  logic          last_pick, cur;
  logic [AW-1:0] rd_idx, last_idx;
  logic          any, pick, hit, ins;
  hdr_t          cand;

  always_comb begin
    any  = |pend;
    pick = (pend[0] && pend[1]) ? ~last_pick : pend[1];
    cand = lane_hdr[pick];
    ins  = (st == M_IDLE) && any && !hit;
    release_o = '0;
    if (st == M_IDLE && any && hit) release_o[pick] = 1'b1;
    if (st == M_SEND && rd_idx == last_idx) release_o[cur] = 1'b1;
  end

  phv_dedup_table #(.DEPTH(DEDUP_DEPTH), .KW(24)) u_hist (
    .clk     (clk),
    .rst     (rst),
    .lk_key  ({cand.snode, cand.seq}),
    .hit     (hit),
    .ins     (ins),
    .ins_key ({cand.snode, cand.seq})
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= M_IDLE;
      last_pick <= 1'b1;
      cur       <= 1'b0;
      rd_idx    <= '0;
      last_idx  <= '0;
      out_valid <= 1'b0;
      out_sop   <= 1'b0;
      out_eop   <= 1'b0;
      out_hdr   <= '0;
      out_diag  <= 1'b0;
    end else begin
      case (st)
        M_IDLE: begin
          out_valid <= 1'b0;
          out_sop   <= 1'b0;
          out_eop   <= 1'b0;
          if (any) begin
            last_pick <= pick;
            if (!hit) begin
              cur      <= pick;
              out_hdr  <= cand;
              out_diag <= cand.func[7];
              last_idx <= AW'(HDR_BYTES - 1) + AW'(cand.plen);
              rd_idx   <= '0;
              st       <= M_SEND;
            end
          end
        end
        default: begin
          out_valid <= 1'b1;
          out_sop   <= (rd_idx == '0);
          out_eop   <= (rd_idx == last_idx);
          rd_idx    <= rd_idx + AW'(1);
          if (rd_idx == last_idx) st <= M_IDLE;
        end
      endcase
    end
  end

  assign rd_addr  = rd_idx;
  assign out_data = lane_q[cur];
endmodule

// File: rtl/phv_top.sv
module phv_top
  import phv_pkg::*;
#(
  parameter logic [7:0] MAGIC       = 8'hA5,
  parameter int         MAX_PAYLOAD = 255,
  parameter int         DEDUP_DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  rx_valid,
  input  logic [1:0]  rx_sop,
  input  logic [15:0] rx_data,
  output logic        out_valid,
  output logic        out_sop,
  output logic        out_eop,
  output logic [7:0]  out_data,
  output logic [7:0]  out_ver,
  output logic [7:0]  out_qos,
  output logic [7:0]  out_ttl,
  output logic [7:0]  out_xcvr,
  output logic [7:0]  out_func,
  output logic        out_diag,
  output logic [7:0]  out_plen,
  output logic [15:0] out_src,
  output logic [15:0] out_dst,
  output logic [7:0]  out_snode,
  output logic [7:0]  out_tnode,
  output logic [15:0] out_seq
);
  localparam int NUM_RX = 2;
  localparam int AW     = $clog2(HDR_BYTES + MAX_PAYLOAD + 2);

  logic [NUM_RX-1:0]      pend, rel;
  hdr_t [NUM_RX-1:0]      lhdr;
  logic [NUM_RX-1:0][7:0] lq;
  logic [AW-1:0]          rd_addr;
  hdr_t                   ohdr;

  for (genvar g = 0; g < NUM_RX; g++) begin : g_lane
    phv_rx_lane #(.MAGIC(MAGIC), .MAX_PAYLOAD(MAX_PAYLOAD), .AW(AW)) u_lane (
      .clk        (clk),
      .rst        (rst),
      .in_valid   (rx_valid[g]),
      .in_sop     (rx_sop[g]),
      .in_data    (rx_data[g*8 +: 8]),
      .rd_addr    (rd_addr),
      .release_i  (rel[g]),
      .pend_o     (pend[g]),
      .pend_hdr_o (lhdr[g]),
      .rd_q_o     (lq[g])
    );
  end

  phv_merge #(.AW(AW), .DEDUP_DEPTH(DEDUP_DEPTH)) u_merge (
    .clk       (clk),
    .rst       (rst),
    .pend      (pend),
    .lane_hdr  (lhdr),
    .lane_q    (lq),
    .rd_addr   (rd_addr),
    .release_o (rel),
    .out_valid (out_valid),
    .out_sop   (out_sop),
    .out_eop   (out_eop),
    .out_data  (out_data),
    .out_hdr   (ohdr),
    .out_diag  (out_diag)
  );

  assign out_ver   = ohdr.ver;
  assign out_qos   = ohdr.qos;
  assign out_ttl   = ohdr.ttl;
  assign out_xcvr  = ohdr.xcvr;
  assign out_func  = ohdr.func;
  assign out_plen  = ohdr.plen;
  assign out_src   = ohdr.src;
  assign out_dst   = ohdr.dst;
  assign out_snode = ohdr.snode;
  assign out_tnode = ohdr.tnode;
  assign out_seq   = ohdr.seq;
endmodule

// File: rtl/phv_checks.sv
module phv_checks #(
  parameter logic [7:0] MAGIC = 8'hA5
) (
  input logic        clk,
  input logic        rst,
  input logic        out_valid,
  input logic        out_sop,
  input logic        out_eop,
  input logic [7:0]  out_data,
  input logic [7:0]  out_ttl,
  input logic [7:0]  out_snode,
  input logic [15:0] out_seq
);
  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !out_valid);

  a_r6_sop_has_valid: assert property (@(posedge clk) disable iff (rst)
    out_sop |-> out_valid);

  a_r6_eop_has_valid: assert property (@(posedge clk) disable iff (rst)
    out_eop |-> out_valid);

  a_r6_contiguous: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_eop) |=> (out_valid && !out_sop));

  a_r2_sideband_stable: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_sop) |-> ($stable(out_seq) && $stable(out_snode)));

  a_r3_marker_first: assert property (@(posedge clk) disable iff (rst)
    out_sop |-> (out_data == MAGIC));

  a_r5_ttl_decremented: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_ttl != 8'hFF));
endmodule

bind phv_top phv_checks #(.MAGIC(MAGIC)) u_checks (
  .clk       (clk),
  .rst       (rst),
  .out_valid (out_valid),
  .out_sop   (out_sop),
  .out_eop   (out_eop),
  .out_data  (out_data),
  .out_ttl   (out_ttl),
  .out_snode (out_snode),
  .out_seq   (out_seq)
);

// File: tb/test_phv_top.sv
module test_phv_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        v0 = 0, v1 = 0, s0 = 0, s1 = 0;
  logic [7:0]  d0 = 0, d1 = 0;
  logic        out_valid, out_sop, out_eop, out_diag;
  logic [7:0]  out_data, out_ver, out_qos, out_ttl, out_xcvr, out_func, out_plen;
  logic [7:0]  out_snode, out_tnode;
  logic [15:0] out_src, out_dst, out_seq;

  always #2 clk = ~clk;

  phv_top i_phv_top (
    .clk(clk), .rst(rst),
    .rx_valid({v1, v0}), .rx_sop({s1, s0}), .rx_data({d1, d0}),
    .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop), .out_data(out_data),
    .out_ver(out_ver), .out_qos(out_qos), .out_ttl(out_ttl), .out_xcvr(out_xcvr),
    .out_func(out_func), .out_diag(out_diag), .out_plen(out_plen), .out_src(out_src),
    .out_dst(out_dst), .out_snode(out_snode), .out_tnode(out_tnode), .out_seq(out_seq)
  );

  int n_tests = 0, n_fail = 0, cyc = 0, t_last = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // ---------------- monitor ----------------
  logic [7:0]  rec [0:299];
  int          rec_cnt = 0, pkts = 0, sop_cyc = 0;
  logic [15:0] cap_seq = 0, prev_seq = 0, cap_src = 0;
  logic [7:0]  cap_ttl = 0, cap_plen = 0, cap_snode = 0;
  logic        cap_diag = 0;

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (out_sop) begin
        rec_cnt  = 0;
        pkts     = pkts + 1;
        sop_cyc  = cyc;
        prev_seq = cap_seq;
        cap_seq  = out_seq;
        cap_src  = out_src;
        cap_ttl  = out_ttl;
        cap_plen = out_plen;
        cap_snode = out_snode;
        cap_diag = out_diag;
      end
      if (rec_cnt < 300) rec[rec_cnt] = out_data;
      rec_cnt = rec_cnt + 1;
    end
  end

  // ---------------- helpers ----------------
  logic [7:0] pbuf [2][0:299];
  int         plen_n [2];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic build(input int b, input logic [7:0] node, input logic [15:0] seq,
                       input logic [7:0] ttl, input logic [7:0] len, input logic [7:0] func,
                       input bit bad_mag, input bit bad_ck);
    int s;
    pbuf[b][0]  = bad_mag ? 8'h5A : 8'hA5;
    pbuf[b][1]  = 8'h01;  pbuf[b][2]  = 8'h02;  pbuf[b][3] = ttl;
    pbuf[b][4]  = 8'h03;  pbuf[b][5]  = func;   pbuf[b][6] = len;
    pbuf[b][7]  = 8'h11;  pbuf[b][8]  = node;
    pbuf[b][9]  = 8'h22;  pbuf[b][10] = 8'h00;
    pbuf[b][11] = node;   pbuf[b][12] = 8'h44;
    pbuf[b][13] = seq[15:8]; pbuf[b][14] = seq[7:0];
    for (int k = 0; k < int'(len); k++) pbuf[b][15+k] = 8'(int'(seq[7:0]) + k * 7 + 3);
    s = 0;
    for (int k = 0; k < 15 + int'(len); k++) s = s + int'(pbuf[b][k]);
    while ((s >> 16) != 0) s = (s & 32'hFFFF) + (s >> 16);
    if (bad_ck) s = s ^ 1;
    pbuf[b][15+len] = 8'(s >> 8);
    pbuf[b][16+len] = 8'(s);
    plen_n[b] = 17 + int'(len);
  endtask

  task automatic drive(input int lane, input logic v, input logic s, input logic [7:0] d);
    if (lane == 0) begin v0 = v; s0 = s; d0 = d; end
    else           begin v1 = v; s1 = s; d1 = d; end
  endtask

  task automatic send(input int lane, input int b, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (k == n - 1) t_last = cyc;
      drive(lane, 1'b1, k == 0, pbuf[b][k]);
    end
    @(negedge clk);
    drive(lane, 1'b0, 1'b0, 8'h00);
  endtask

  task automatic send_mask(input logic [1:0] mask, input int b);
    fork
      begin if (mask[0]) send(0, b, plen_n[b]); end
      begin if (mask[1]) begin repeat (3) @(negedge clk); send(1, b, plen_n[b]); end end
    join
  endtask

  task automatic compare_fwd(input int b, input string req);
    int bad = 0;
    int n = plen_n[b] - 2;
    for (int k = 0; k < n; k++) begin
      logic [7:0] e;
      e = (k == 3) ? pbuf[b][3] - 8'd1 : pbuf[b][k];
      if (rec[k] !== e) bad++;
    end
    check(rec_cnt == n, {req, " length"}, rec_cnt, n);
    check(bad == 0, {req, " bytes"}, bad, 0);
    check(cap_ttl == pbuf[b][3] - 8'd1, "R5 ttl sideband", int'(cap_ttl), int'(pbuf[b][3]) - 1);
    check(cap_seq == {pbuf[b][13], pbuf[b][14]}, "R2 seq sideband", int'(cap_seq),
          int'({pbuf[b][13], pbuf[b][14]}));
    check(cap_src == {pbuf[b][7], pbuf[b][8]}, "R2 src sideband", int'(cap_src),
          int'({pbuf[b][7], pbuf[b][8]}));
    check(cap_plen == pbuf[b][6], "R2 length sideband", int'(cap_plen), int'(pbuf[b][6]));
    check(cap_diag == pbuf[b][5][7], "R9 diag flag", int'(cap_diag), int'(pbuf[b][5][7]));
  endtask

  // ---------------- vector table ----------------
  typedef struct packed {
    logic [1:0]  mask;
    logic [7:0]  node;
    logic [15:0] seq;
    logic [7:0]  ttl;
    logic [7:0]  len;
    logic [7:0]  func;
    logic        bad_mag;
    logic        bad_ck;
    logic        fwd;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{2'd3, 8'd1, 16'd100,   8'd5,   8'd4,  8'h01, 1'b0, 1'b0, 1'b1, 4'd2},  // R2, R7 copy on lane 1
    '{2'd1, 8'd1, 16'd101,   8'd1,   8'd0,  8'h80, 1'b0, 1'b0, 1'b1, 4'd9},  // R9 diagnostic, empty payload
    '{2'd2, 8'd2, 16'd100,   8'd9,   8'd20, 8'h01, 1'b0, 1'b0, 1'b1, 4'd7},  // R7 other node, same seq
    '{2'd3, 8'd1, 16'd100,   8'd5,   8'd4,  8'h01, 1'b0, 1'b0, 1'b0, 4'd7},  // R7 repeat dropped
    '{2'd1, 8'd3, 16'd7,     8'd0,   8'd2,  8'h01, 1'b0, 1'b0, 1'b0, 4'd5},  // R5 hop counter zero
    '{2'd3, 8'd3, 16'd8,     8'd4,   8'd2,  8'h01, 1'b1, 1'b0, 1'b0, 4'd3},  // R3 bad marker
    '{2'd1, 8'd3, 16'd9,     8'd4,   8'd2,  8'h01, 1'b0, 1'b1, 1'b0, 4'd4},  // R4 bad checksum
    '{2'd3, 8'd3, 16'd9,     8'd2,   8'd3,  8'h01, 1'b0, 1'b0, 1'b1, 4'd4},  // R4 same pair, good now
    '{2'd3, 8'd4, 16'hFFFF,  8'd255, 8'd40, 8'h7F, 1'b0, 1'b0, 1'b1, 4'd6}   // R6 long packet
  };

  task automatic run_one(input logic [1:0] mask, input logic [7:0] node, input logic [15:0] seq,
                         input logic [7:0] ttl, input logic [7:0] len, input logic [7:0] func,
                         input bit bm, input bit bc, input bit fwd, input string req);
    int base;
    base = pkts;
    build(0, node, seq, ttl, len, func, bm, bc);
    send_mask(mask, 0);
    repeat (int'(len) + 40) @(negedge clk);
    check((pkts - base) == int'(fwd), {req, " forwarded count"}, pkts - base, int'(fwd));
    if (fwd && pkts - base == 1) compare_fwd(0, req);
  endtask

  // ---------------- main ----------------
  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check(out_valid == 1'b0, "R1 idle after reset", int'(out_valid), 0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      run_one(v.mask, v.node, v.seq, v.ttl, v.len, v.func, v.bad_mag, v.bad_ck, v.fwd,
              $sformatf("R%0d", v.req));
    end

    // R8: four more entries wrap the history past its oldest pair (1,100)
    for (int k = 1; k <= 4; k++)
      run_one(2'd1, 8'd6, 16'(k), 8'd3, 8'd1, 8'h01, 0, 0, 1, "R8 fill");
    run_one(2'd1, 8'd1, 16'd101, 8'd1, 8'd0, 8'h80, 0, 0, 0, "R8 still held");
    run_one(2'd1, 8'd1, 16'd100, 8'd5, 8'd4, 8'h01, 0, 0, 1, "R8 evicted pair");

    // R12: latency from last checksum byte to out_sop, merge stage idle
    begin
      int base;
      base = pkts;
      build(0, 8'd9, 16'd1, 8'd7, 8'd2, 8'h01, 0, 0);
      send(0, 0, plen_n[0]);
      repeat (40) @(negedge clk);
      check(pkts - base == 1, "R12 packet seen", pkts - base, 1);
      check(sop_cyc - t_last == 3, "R12 sop latency", sop_cyc - t_last, 3);
    end

    // R10: stray bytes ignored, then a packet abandoned by a new start marker
    begin
      int base;
      base = pkts;
      for (int k = 0; k < 5; k++) begin
        @(negedge clk);
        drive(0, 1'b1, 1'b0, 8'hA5);
      end
      @(negedge clk);
      drive(0, 1'b0, 1'b0, 8'h00);
      repeat (20) @(negedge clk);
      check(pkts == base, "R10 stray bytes ignored", pkts - base, 0);
      build(0, 8'd10, 16'd1, 8'd4, 8'd5, 8'h01, 0, 0);
      build(1, 8'd10, 16'd2, 8'd4, 8'd3, 8'h01, 0, 0);
      send(0, 0, 6);
      send(0, 1, plen_n[1]);
      repeat (50) @(negedge clk);
      check(pkts - base == 1, "R10 restart count", pkts - base, 1);
      check(cap_seq == 16'd2, "R10 restart seq", int'(cap_seq), 2);
      compare_fwd(1, "R10");
    end

    // R11: distinct packets completing in the same cycle on both lanes
    begin
      int base;
      base = pkts;
      build(0, 8'd11, 16'd1, 8'd4, 8'd6, 8'h01, 0, 0);
      build(1, 8'd11, 16'd2, 8'd4, 8'd6, 8'h01, 0, 0);
      fork
        send(0, 0, plen_n[0]);
        send(1, 1, plen_n[1]);
      join
      repeat (80) @(negedge clk);
      check(pkts - base == 2, "R11 both forwarded", pkts - base, 2);
      check((prev_seq + cap_seq == 16'd3) && (prev_seq != cap_seq), "R11 both seqs",
            int'(prev_seq) * 100 + int'(cap_seq), 102);
    end

    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule